// File: doc/BRIEF.md
# Voice Trigger Mode Controller

This block sits in front of a voice-group sequencer and turns raw, active-high push-button or host inputs into two registered commands: a start strobe carrying the number of the group to play, and a stop strobe. Four select lines, one sequence/strobe line and a master-stop line arrive from pads. A sample-rate tick paces the input filters. Option inputs give the chip-wide mode (key or host binary select) and three option bits for each group: edge or level trigger, holdable or unholdable, and retriggerable or not. The sequencer reports the end of each group with a one-cycle pulse.

In key mode each of the four select lines owns one of the first four groups. The strobe line walks through the remaining groups one press at a time and wraps after a configured last group. In host mode the four select lines form a binary code that a strobe pulse latches. Two codes are illegal. The block tracks the group it launched so that it can apply hold, retrigger and loop rules until the group ends or is stopped.

Top module: `voice_trig_ctrl`

## Requirements
- R1: In key mode a debounced rising edge on select line k (k = 0..3) gives one start_o pulse with start_grp_o = k+1.
- R2: In key mode a debounced rising edge on seq_i starts the group held in a sequence pointer. The pointer begins at 5 and moves to the next group after each start it issues. After the group equal to last_grp_i (or the highest group) it wraps to 5.
- R3: In host mode (cpu_mode_i = 1) select-line edges start nothing. A debounced rising edge on seq_i reads code = {trig_i[3], trig_i[2], trig_i[1], trig_i[0]} and starts group code+1.
- R4: In host mode the codes 14 and 15 start nothing. Every start_o carries a group from 1 to NUM_GROUPS.
- R5: A filtered input changes only after its synchronised raw value has disagreed with it for KEY_DEB_TICKS consecutive ticks in key mode, or CPU_DEB_TICKS ticks in host mode. Shorter pulses have no effect.
- R6: While a holdable group plays, the filtered level of the input that launched it falling low gives one stop_o pulse and ends playback.
- R7: While an unholdable group plays, releasing its input has no effect and no stop_o is issued. At grp_end_i the block goes idle unless R8 applies.
- R8: For a level-triggered group whose launching input is still high at grp_end_i, the block issues a start_o for the same group.
- R9: For an edge-triggered group, an input still held at grp_end_i does not restart it. Only a new rising edge does.
- R10: While a retriggerable group plays, a new request at once starts the requested group. A non-retriggerable group ignores new requests until it ends.
- R11: While irp_i is high, stop_o is high and start_o low, starting within three cycles. The input filters clear, playback state clears and the sequence pointer returns to 5.
- R12: When several requests rise in the same cycle, the lowest select line wins, and any select line wins over seq_i.
- R13: After reset start_o = 0, stop_o = 0 and start_grp_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle sample-rate tick for the filters |
| trig_i | input | 4 | Raw select lines; binary code in host mode, bit 0 LSB |
| seq_i | input | 1 | Raw sequence button / host strobe |
| irp_i | input | 1 | Raw master stop, active high |
| cpu_mode_i | input | 1 | 1 = host binary-select mode, 0 = key mode |
| grp_edge_i | input | NUM_GROUPS | Per group: 1 = edge trigger, 0 = level trigger (bit g-1 for group g) |
| grp_hold_i | input | NUM_GROUPS | Per group: 1 = holdable |
| grp_retrig_i | input | NUM_GROUPS | Per group: 1 = retriggerable |
| last_grp_i | input | 4 | Last group of the key-mode sequence (5..NUM_GROUPS) |
| grp_end_i | input | 1 | One-cycle pulse from the sequencer when the group ends |
| start_o | output | 1 | Start strobe |
| start_grp_o | output | 4 | Group number (1..NUM_GROUPS) for start_o |
| stop_o | output | 1 | Stop strobe |

## Verification
Several rules are checked by assertions on every cycle. A filter never moves without a tick. The master stop always forces a stop and blocks any start. A holdable group that loses its input is stopped. An unholdable group never receives a stop. A non-retriggerable group can only be relaunched as itself. Start numbers and the sequence pointer stay in range. Only the directed scenarios can show that the right group number comes from each line and code, the debounce length, the sequence order and wrap, the priority among simultaneous presses, and the difference between level looping and edge one-shot play.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

    localparam int KEYS   = 4;              // select lines, also host code width
    localparam int CHANS  = KEYS + 1;       // select lines plus sequence/strobe
    localparam int SEQ_CH = KEYS;           // channel index of the strobe line
    localparam int GRP_W  = 4;
    localparam int SRC_W  = $clog2(CHANS);

    typedef logic [GRP_W-1:0] grp_t;
    typedef logic [SRC_W-1:0] src_t;

    typedef struct packed {
        logic act;      // a launched group is considered playing
        grp_t grp;      // group being played
        src_t src;      // channel that launched it
        grp_t seq;      // next key-mode sequence group
        logic start;
        grp_t sgrp;
        logic stop;
    } eng_t;

    function automatic grp_t seq_step(grp_t cur, grp_t last, grp_t first, grp_t top);
        if (cur >= last || cur >= top) begin
            return first;
        end
        return cur + grp_t'(1);
    endfunction

endpackage

// File: rtl/vtc_deb_chan.sv
module vtc_deb_chan #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             level_o,
    output logic             rise_o
);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic [CNT_W-1:0] cnt;
        logic             lvl;
        logic             rise;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw_i;
        st_d.s2   = st_q.s1;
        st_d.rise = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b0;
        end else if (st_q.s2 == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if ((st_q.cnt + CNT_W'(1)) >= thr_i) begin
                st_d.lvl  = st_q.s2;
                st_d.rise = st_q.s2;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.lvl;
    assign rise_o  = st_q.rise;

    // R5: the filtered level only moves on a tick (or a clear)
    p_filter_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(level_o));

endmodule

// File: rtl/vtc_req_dec.sv
module vtc_req_dec
    import vtc_pkg::*;
#(
    parameter int NUM_GROUPS = 14
) (
    input  logic [CHANS-1:0] lvl_i,
    input  logic [CHANS-1:0] rise_i,
    input  logic             cpu_mode_i,
    input  grp_t             seq_grp_i,
    output logic             req_vld_o,
    output grp_t             req_grp_o,
    output src_t             req_src_o,
    output logic             req_seq_o
);

    logic [KEYS-1:0] code;

    always_comb begin
        req_vld_o = 1'b0;
        req_grp_o = '0;
        req_src_o = '0;
        req_seq_o = 1'b0;
        code      = lvl_i[KEYS-1:0];
        if (cpu_mode_i) begin
            if (rise_i[SEQ_CH] && (int'(code) < NUM_GROUPS)) begin
                req_vld_o = 1'b1;
                req_grp_o = grp_t'(int'(code) + 1);
                req_src_o = src_t'(SEQ_CH);
            end
        end else begin
            if (rise_i[SEQ_CH]) begin
                req_vld_o = 1'b1;
                req_grp_o = seq_grp_i;
                req_src_o = src_t'(SEQ_CH);
                req_seq_o = 1'b1;
            end
            // descending scan so the lowest line is assigned last and wins
            for (int j = KEYS - 1; j >= 0; j--) begin
                if (rise_i[j]) begin
                    req_vld_o = 1'b1;
                    req_grp_o = grp_t'(j + 1);
                    req_src_o = src_t'(j);
                    req_seq_o = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/vtc_play_ctrl.sv
module vtc_play_ctrl
    import vtc_pkg::*;
#(
    parameter int NUM_GROUPS    = 14,
    parameter int FIRST_SEQ_GRP = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  irp_i,
    input  logic                  req_vld_i,
    input  grp_t                  req_grp_i,
    input  src_t                  req_src_i,
    input  logic                  req_seq_i,
    input  logic [CHANS-1:0]      lvl_i,
    input  logic [NUM_GROUPS-1:0] edge_i,
    input  logic [NUM_GROUPS-1:0] hold_i,
    input  logic [NUM_GROUPS-1:0] retrig_i,
    input  grp_t                  last_grp_i,
    input  logic                  grp_end_i,
    output grp_t                  seq_grp_o,
    output logic                  start_o,
    output grp_t                  start_grp_o,
    output logic                  stop_o
);

    localparam grp_t FIRST = grp_t'(FIRST_SEQ_GRP);
    localparam grp_t TOP   = grp_t'(NUM_GROUPS);

    function automatic logic opt_of(logic [NUM_GROUPS-1:0] v, grp_t g);
        if (g == '0 || int'(g) > NUM_GROUPS) begin
            return 1'b0;
        end
        return v[int'(g) - 1];
    endfunction

    eng_t st_d, st_q;
    logic cur_edge, cur_hold, cur_retrig, src_lvl, take;

    always_comb begin
        cur_edge   = opt_of(edge_i,   st_q.grp);
        cur_hold   = opt_of(hold_i,   st_q.grp);
        cur_retrig = opt_of(retrig_i, st_q.grp);
        src_lvl    = (int'(st_q.src) < CHANS) ? lvl_i[st_q.src] : 1'b0;
        take       = 1'b0;

        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.stop  = 1'b0;

        if (irp_i) begin
            st_d.act  = 1'b0;
            st_d.grp  = '0;
            st_d.src  = '0;
            st_d.seq  = FIRST;
            st_d.stop = 1'b1;
        end else if (st_q.act) begin
            if (cur_hold && !src_lvl) begin
                st_d.act  = 1'b0;
                st_d.stop = 1'b1;
            end else if (req_vld_i && cur_retrig) begin
                take = 1'b1;
            end else if (grp_end_i) begin
                if (!cur_edge && src_lvl) begin
                    st_d.start = 1'b1;
                    st_d.sgrp  = st_q.grp;
                end else begin
                    st_d.act = 1'b0;
                end
            end
        end else if (req_vld_i) begin
            take = 1'b1;
        end

        if (take) begin
            st_d.act   = 1'b1;
            st_d.grp   = req_grp_i;
            st_d.src   = req_src_i;
            st_d.start = 1'b1;
            st_d.sgrp  = req_grp_i;
            if (req_seq_i) begin
                st_d.seq = seq_step(st_q.seq, last_grp_i, FIRST, TOP);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.seq <= FIRST;
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_grp_o   = st_q.seq;
    assign start_o     = st_q.start;
    assign start_grp_o = st_q.sgrp;
    assign stop_o      = st_q.stop;

    p_irp_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irp_i |=> (stop_o && !start_o));

    p_grp_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (start_grp_o != '0 && int'(start_grp_o) <= NUM_GROUPS));

    p_nonretrig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !cur_retrig && !irp_i) |=> (!start_o || start_grp_o == $past(st_q.grp)));

    p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && cur_hold && !src_lvl && !irp_i) |=> stop_o);

    p_unhold_no_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !cur_hold && !irp_i) |=> !stop_o);

    p_seq_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_grp_o >= FIRST && seq_grp_o <= TOP));

endmodule

// File: rtl/voice_trig_ctrl.sv
module voice_trig_ctrl
    import vtc_pkg::*;
#(
    parameter int NUM_GROUPS    = 14,
    parameter int KEY_DEB_TICKS = 126,
    parameter int CPU_DEB_TICKS = 1,
    parameter int FIRST_SEQ_GRP = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic [3:0]            trig_i,
    input  logic                  seq_i,
    input  logic                  irp_i,
    input  logic                  cpu_mode_i,
    input  logic [NUM_GROUPS-1:0] grp_edge_i,
    input  logic [NUM_GROUPS-1:0] grp_hold_i,
    input  logic [NUM_GROUPS-1:0] grp_retrig_i,
    input  logic [3:0]            last_grp_i,
    input  logic                  grp_end_i,
    output logic                  start_o,
    output logic [3:0]            start_grp_o,
    output logic                  stop_o
);

    localparam int MAX_DEB = (KEY_DEB_TICKS > CPU_DEB_TICKS) ? KEY_DEB_TICKS : CPU_DEB_TICKS;
    localparam int CNT_W   = $clog2(MAX_DEB + 1);

    typedef struct packed {
        logic s1;
        logic s2;
    } irp_sync_t;

    irp_sync_t irp_d, irp_q;

    always_comb begin
        irp_d.s1 = irp_i;
        irp_d.s2 = irp_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irp_q <= '0;
        end else begin
            irp_q <= irp_d;
        end
    end

    logic [CNT_W-1:0] thr;
    logic [CHANS-1:0] raw, lvl, rise;

    assign thr = cpu_mode_i ? CNT_W'(CPU_DEB_TICKS) : CNT_W'(KEY_DEB_TICKS);
    assign raw = {seq_i, trig_i};

    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        vtc_deb_chan #(
            .CNT_W (CNT_W)
        ) deb_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .clr_i   (irp_q.s2),
            .raw_i   (raw[c]),
            .thr_i   (thr),
            .level_o (lvl[c]),
            .rise_o  (rise[c])
        );
    end

    grp_t seq_grp, req_grp;
    src_t req_src;
    logic req_vld, req_seq;

    vtc_req_dec #(
        .NUM_GROUPS (NUM_GROUPS)
    ) dec_i (
        .lvl_i      (lvl),
        .rise_i     (rise),
        .cpu_mode_i (cpu_mode_i),
        .seq_grp_i  (seq_grp),
        .req_vld_o  (req_vld),
        .req_grp_o  (req_grp),
        .req_src_o  (req_src),
        .req_seq_o  (req_seq)
    );

    vtc_play_ctrl #(
        .NUM_GROUPS    (NUM_GROUPS),
        .FIRST_SEQ_GRP (FIRST_SEQ_GRP)
    ) eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irp_i       (irp_q.s2),
        .req_vld_i   (req_vld),
        .req_grp_i   (req_grp),
        .req_src_i   (req_src),
        .req_seq_i   (req_seq),
        .lvl_i       (lvl),
        .edge_i      (grp_edge_i),
        .hold_i      (grp_hold_i),
        .retrig_i    (grp_retrig_i),
        .last_grp_i  (last_grp_i),
        .grp_end_i   (grp_end_i),
        .seq_grp_o   (seq_grp),
        .start_o     (start_o),
        .start_grp_o (start_grp_o),
        .stop_o      (stop_o)
    );

endmodule

// File: tb/voice_trig_ctrl_tb_top.sv
module voice_trig_ctrl_tb_top;

    localparam int NG  = 14;
    localparam int KW  = 140;   // ticks: comfortably past key debounce
    localparam int KS  = 100;   // ticks: short of key debounce

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [3:0]    trig = '0;
    logic          seq = 1'b0;
    logic          irp = 1'b0;
    logic          cpu_mode = 1'b0;
    logic [NG-1:0] g_edge = '1;
    logic [NG-1:0] g_hold = '0;
    logic [NG-1:0] g_retrig = '0;
    logic [3:0]    last_grp = 4'd14;
    logic          grp_end = 1'b0;
    logic          start_o, stop_o;
    logic [3:0]    start_grp_o;

    int vectors = 0;
    int fails   = 0;
    int n_start = 0;
    int n_stop  = 0;
    int last_g  = 0;
    int tcnt    = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
        tick <= (tcnt == 3);
    end

    voice_trig_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .trig_i       (trig),
        .seq_i        (seq),
        .irp_i        (irp),
        .cpu_mode_i   (cpu_mode),
        .grp_edge_i   (g_edge),
        .grp_hold_i   (g_hold),
        .grp_retrig_i (g_retrig),
        .last_grp_i   (last_grp),
        .grp_end_i    (grp_end),
        .start_o      (start_o),
        .start_grp_o  (start_grp_o),
        .stop_o       (stop_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (start_o) begin
                n_start <= n_start + 1;
                last_g  <= int'(start_grp_o);
            end
            if (stop_o) n_stop <= n_stop + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wt(int ticks);
        repeat (ticks * 4) @(negedge clk);
        #1;
    endtask

    task automatic end_pulse();
        @(negedge clk) grp_end = 1'b1;
        @(negedge clk) grp_end = 1'b0;
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic defaults();
        g_edge = '1; g_hold = '0; g_retrig = '0; last_grp = 4'd14;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R13 start_o", int'(start_o), 0);
        chk("R13 stop_o", int'(stop_o), 0);
        chk("R13 start_grp_o", int'(start_grp_o), 0);
    endtask

    task automatic t_keys();
        defaults();
        for (int k = 0; k < 4; k++) begin
            int s0 = n_start;
            @(negedge clk) trig[k] = 1'b1;
            wt(KW);
            chk("R1 start count", n_start - s0, 1);
            chk("R1 group", last_g, k + 1);
            @(negedge clk) trig[k] = 1'b0;
            wt(KW);
            end_pulse();
        end
    endtask

    task automatic t_debounce();
        int s0;
        defaults();
        s0 = n_start;
        @(negedge clk) trig[1] = 1'b1;
        wt(KS);
        @(negedge clk) trig[1] = 1'b0;
        wt(KW);
        chk("R5 short press ignored", n_start - s0, 0);
    endtask

    task automatic t_seq();
        int exp_g [4] = '{5, 6, 7, 5};
        defaults();
        last_grp = 4'd7;
        for (int i = 0; i < 4; i++) begin
            int s0 = n_start;
            @(negedge clk) seq = 1'b1;
            wt(KW);
            chk("R2 seq start", n_start - s0, 1);
            chk("R2 seq group", last_g, exp_g[i]);
            @(negedge clk) seq = 1'b0;
            wt(KW);
            end_pulse();
        end
    endtask

    task automatic t_priority();
        int s0;
        defaults();
        s0 = n_start;
        @(negedge clk) begin trig[1] = 1'b1; trig[0] = 1'b1; seq = 1'b1; end
        wt(KW);
        chk("R12 single start", n_start - s0, 1);
        chk("R12 lowest wins", last_g, 1);
        @(negedge clk) begin trig = '0; seq = 1'b0; end
        wt(KW);
        end_pulse();
    endtask

    task automatic t_hold();
        int p0;
        defaults();
        g_hold[1] = 1'b1;
        @(negedge clk) trig[1] = 1'b1;
        wt(KW);
        chk("R6 started group", last_g, 2);
        p0 = n_stop;
        @(negedge clk) trig[1] = 1'b0;
        wt(KW);
        chk("R6 release stops", n_stop - p0, 1);
    endtask

    task automatic t_unhold();
        int p0, s0;
        defaults();
        p0 = n_stop;
        @(negedge clk) trig[2] = 1'b1;
        wt(KW);
        chk("R7 started group", last_g, 3);
        @(negedge clk) trig[2] = 1'b0;
        wt(KW);
        chk("R7 release no stop", n_stop - p0, 0);
        s0 = n_start;
        end_pulse();
        chk("R7 end no stop", n_stop - p0, 0);
        chk("R7 end no restart", n_start - s0, 0);
        @(negedge clk) trig[3] = 1'b1;
        wt(KW);
        chk("R7 idle after end", last_g, 4);
        @(negedge clk) trig[3] = 1'b0;
        wt(KW);
        end_pulse();
    endtask

    task automatic t_level();
        int s0;
        defaults();
        g_edge[0] = 1'b0;
        @(negedge clk) trig[0] = 1'b1;
        wt(KW);
        s0 = n_start;
        end_pulse();
        chk("R8 held restarts", n_start - s0, 1);
        chk("R8 same group", last_g, 1);
        @(negedge clk) trig[0] = 1'b0;
        wt(KW);
        s0 = n_start;
        end_pulse();
        chk("R8 released no restart", n_start - s0, 0);
    endtask

    task automatic t_edge();
        int s0;
        defaults();
        @(negedge clk) trig[3] = 1'b1;
        wt(KW);
        chk("R9 started group", last_g, 4);
        s0 = n_start;
        end_pulse();
        chk("R9 held no restart", n_start - s0, 0);
        @(negedge clk) trig[3] = 1'b0;
        wt(KW);
    endtask

    task automatic t_retrig();
        int s0;
        defaults();
        @(negedge clk) trig[0] = 1'b1;
        wt(KW);
        @(negedge clk) trig[0] = 1'b0;
        wt(KW);
        s0 = n_start;
        @(negedge clk) trig[1] = 1'b1;
        wt(KW);
        chk("R10 non-retrig ignores", n_start - s0, 0);
        @(negedge clk) trig[1] = 1'b0;
        wt(KW);
        end_pulse();
        g_retrig[2] = 1'b1;
        @(negedge clk) trig[2] = 1'b1;
        wt(KW);
        @(negedge clk) trig[2] = 1'b0;
        wt(KW);
        s0 = n_start;
        @(negedge clk) trig[1] = 1'b1;
        wt(KW);
        chk("R10 retrig switches", n_start - s0, 1);
        chk("R10 retrig group", last_g, 2);
        @(negedge clk) trig[1] = 1'b0;
        wt(KW);
        end_pulse();
    endtask

    task automatic cpu_try(logic [3:0] code, int exp_n, int exp_g);
        int s0 = n_start;
        @(negedge clk) trig = code;
        wt(5);
        chk("R3 select lines alone start nothing", n_start - s0, 0);
        @(negedge clk) seq = 1'b1;
        wt(5);
        @(negedge clk) seq = 1'b0;
        wt(5);
        if (exp_n == 0) begin
            chk("R4 illegal code no start", n_start - s0, 0);
        end else begin
            chk("R3 host start", n_start - s0, 1);
            chk("R3 host group", last_g, exp_g);
            end_pulse();
        end
        @(negedge clk) trig = '0;
        wt(5);
    endtask

    task automatic t_cpu();
        defaults();
        @(negedge clk) cpu_mode = 1'b1;
        cpu_try(4'b0101, 1, 6);
        cpu_try(4'b0000, 1, 1);
        cpu_try(4'b1101, 1, 14);
        cpu_try(4'b1110, 0, 0);
        cpu_try(4'b1111, 0, 0);
        @(negedge clk) cpu_mode = 1'b0;
        wt(5);
    endtask

    task automatic t_irp();
        int p0, s0;
        defaults();
        last_grp = 4'd7;
        @(negedge clk) seq = 1'b1;
        wt(KW);
        chk("R2 pointer carried over", last_g, 6);
        @(negedge clk) seq = 1'b0;
        wt(KW);
        p0 = n_stop;
        s0 = n_start;
        @(negedge clk) irp = 1'b1;
        repeat (5) @(negedge clk);
        irp = 1'b0;
        wt(4);
        chk("R11 stop cycles", n_stop - p0, 5);
        chk("R11 no start", n_start - s0, 0);
        @(negedge clk) seq = 1'b1;
        wt(KW);
        chk("R11 pointer back to first", last_g, 5);
        @(negedge clk) seq = 1'b0;
        wt(KW);
        end_pulse();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_keys();
        t_debounce();
        t_seq();
        t_priority();
        t_hold();
        t_unhold();
        t_level();
        t_edge();
        t_retrig();
        t_cpu();
        t_irp();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule